// File: doc/BRIEF.md
# Set-Associative Data Cache Controller with MEI Line States

This block is the tag, state and line-storage controller of a data cache. It splits every physical request address into a byte offset, a set index and a tag, looks the tag up across the ways of the indexed set, and answers loads and stores from its own line array. On a miss it picks a victim way, writes that victim back to memory first when it holds dirty data, then fetches the whole requested line from memory in one transfer.

Each line is in one of three states: Invalid, Exclusive (clean copy of memory) or Modified (newer than memory). Besides loads and stores, the request port takes three by-address maintenance commands that act on the whole line containing the address. Clean pushes a dirty line to memory and leaves it clean. Invalidate drops the line. Flush does a clean and then drops the line. The victim policy is least-recently-used or round-robin, chosen at run time by a configuration input. Both policies track state all the time, so the input may change between requests.

The CPU side takes one request at a time. A request is accepted in a cycle where `req_valid` and `req_ready` are both high, and it is answered by a one-cycle `resp_valid` pulse. The memory side moves one full line per handshake.

Top module: `mei_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid and `req_ready` is high. `resp_valid` and `mem_req` are low, and the first access to any address is a miss.
- R2: Address bits [5:0] are the byte within the 64-byte line, bits [5:2] select the 32-bit word, bits [13:6] select one of 256 sets and bits [31:14] form the tag. Every `mem_addr` has bits [5:0] equal to zero.
- R3: A load or store hits only when a way of the indexed set holds the same tag in a state other than Invalid. A hit sets `resp_hit` to 1, causes no memory traffic, and a load hit returns the stored word.
- R4: On a load or store miss the line is read from memory with one read on the memory port, and `resp_hit` is 0. A load fill leaves the line Exclusive and returns the word from memory. A store fill leaves it Modified, with the store word merged in.
- R5: A store hit writes the selected word, sets the line Modified and causes no memory traffic. `resp_rdata` is 0 for every operation other than a load.
- R6: A miss fills the lowest-numbered Invalid way of the set when one exists. The replacement policy is used only when all three ways are valid.
- R7: With `cfg_rr` = 0 the victim is the way of the set that was least recently hit by a load or store or filled.
- R8: With `cfg_rr` = 1 the victim is the per-set round-robin pointer. That pointer starts at way 0 and, on every fill, moves to the way after the one filled (wrapping from 2 to 0).
- R9: A Modified victim is written back, as its full 64-byte line at its own line address, before the fill read is issued. Exclusive and Invalid victims are dropped without a write-back.
- R10: Clean, `req_op` = 2, writes back a Modified line and leaves it Exclusive. On any other line state it causes no memory traffic.
- R11: Invalidate, `req_op` = 3, sets a present line to Invalid without any memory traffic, even when the line was Modified.
- R12: Flush, `req_op` = 4, writes back a Modified line and then sets it Invalid. An Exclusive line becomes Invalid without traffic.
- R13: A maintenance command acts on the whole aligned line containing its address. `resp_hit` reports whether the line was present. An address not in the cache completes with no change and no traffic.
- R14: Encodings are `req_op` 0 load and 1 store. Each accepted request produces exactly one `resp_valid` pulse, after which `req_ready` is high again. `mem_req`, `mem_we` and `mem_addr` stay steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rr | input | 1 | Victim policy: 0 least-recently-used, 1 round-robin |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 3 | 0 load, 1 store, 2 clean, 3 invalidate, 4 flush |
| req_addr | input | 32 | Physical byte address |
| req_wdata | input | 32 | Store word |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Line was present at lookup |
| resp_rdata | output | 32 | Load result, zero otherwise |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 write-back, 0 line read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 512 | Line written back |
| mem_ack | input | 1 | Memory transfer done this cycle |
| mem_rdata | input | 512 | Line read, valid with `mem_ack` |

## Verification
A directed prologue drives one line through every state change. It stores, cleans, cleans again, flushes and reloads, and it uses unaligned addresses so that whole-line action is separated from word action. It then forces a fourth tag into a full set, which tells a least-recently-used victim from a plain lowest-way choice. Constrained-random traffic follows: a few tags per set over a handful of sets, so that conflict misses are frequent and the dirty, clean and empty victims all occur. It runs first under one policy and then the other, with slow and immediate memory acknowledges mixed. A reference model in the bench predicts the hit flag, returned word, write-back address and data, and the fill count for every request, so a wrong victim shows up as an unexpected miss, eviction or stale word later on.

// File: rtl/mei_cache_pkg.sv
package mei_cache_pkg;

   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_EXC = 2'd1,
      LS_MOD = 2'd2
   } line_state_e;

   typedef enum logic [2:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_CLEAN = 3'd2,
      OP_INVAL = 3'd3,
      OP_FLUSH = 3'd4
   } cache_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LOOK,
      S_EVICT,
      S_FILL,
      S_MWB,
      S_DONE
   } ctrl_state_e;

endpackage

// File: rtl/mei_tag_match.sv
module mei_tag_match #(
   parameter int WAYS  = 3,
   parameter int TAG_W = 18,
   parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [TAG_W-1:0] way_tag [WAYS],
   input  logic [WAYS-1:0]  way_valid,
   input  logic [TAG_W-1:0] look_tag,
   output logic [WAYS-1:0]  hit_vec,
   output logic             hit,
   output logic [WAY_W-1:0] hit_way
);

   for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign hit_vec[g] = way_valid[g] && (way_tag[g] == look_tag);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (hit_vec[i]) hit_way = WAY_W'(i);
      end
   end

endmodule

// File: rtl/mei_repl.sv
module mei_repl #(
   parameter int SETS  = 256,
   parameter int WAYS  = 3,
   parameter int IDX_W = $clog2(SETS),
   parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_rr,
   input  logic [IDX_W-1:0] set_idx,
   input  logic [WAYS-1:0]  way_valid,
   output logic [WAY_W-1:0] victim,
   input  logic             upd_touch,
   input  logic             upd_fill,
   input  logic [WAY_W-1:0] upd_way
);

   logic [WAY_W-1:0] age_q [SETS][WAYS];
   logic [WAY_W-1:0] rr_q  [SETS];
   logic [WAY_W-1:0] rr_next;
   logic [WAY_W-1:0] lru_way;
   logic             free_found;

   if (WAYS < 2) begin : g_bad_ways
      $error("mei_repl: WAYS must be at least 2");
   end

   // Pointer wrap: free when WAYS is a power of two, compared otherwise
   if ((1 << WAY_W) == WAYS) begin : g_rr_wrap
      assign rr_next = upd_way + 1'b1;
   end else begin : g_rr_cmp
      assign rr_next = (upd_way == WAY_W'(WAYS-1)) ? '0 : upd_way + 1'b1;
   end

   always_comb begin
      lru_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (age_q[set_idx][w] == WAY_W'(WAYS-1)) lru_way = WAY_W'(w);
      end
      victim     = cfg_rr ? rr_q[set_idx] : lru_way;
      free_found = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (!way_valid[w] && !free_found) begin
            victim     = WAY_W'(w);
            free_found = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            rr_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
         end
      end else begin
         if (upd_touch) begin
            for (int w = 0; w < WAYS; w++) begin
               if (WAY_W'(w) == upd_way)
                  age_q[set_idx][w] <= '0;
               else if (age_q[set_idx][w] < age_q[set_idx][upd_way])
                  age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
            end
         end
         if (upd_fill) rr_q[set_idx] <= rr_next;
      end
   end

   p_touch_mru_r7: assert property (@(posedge clk) disable iff (!rst_n)
      upd_touch |=> (age_q[$past(set_idx)][$past(upd_way)] == '0));

   p_rr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_fill |=> (rr_q[$past(set_idx)] != $past(upd_way)));

   p_victim_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (way_valid != {WAYS{1'b1}}) |-> !way_valid[victim]);

endmodule

// File: rtl/mei_cache_ctrl.sv
module mei_cache_ctrl
   import mei_cache_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SETS       = 256,
   parameter int WAYS       = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_rr,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [2:0]              req_op,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [WORD_W-1:0]       req_wdata,
   output logic                    resp_valid,
   output logic                    resp_hit,
   output logic [WORD_W-1:0]       resp_rdata,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [LINE_BYTES*8-1:0] mem_wdata,
   input  logic                    mem_ack,
   input  logic [LINE_BYTES*8-1:0] mem_rdata
);

   localparam int LINE_W = LINE_BYTES * 8;
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int BOFF_W = $clog2(WORD_W / 8);
   localparam int WSEL_W = $clog2(LINE_W / WORD_W);
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

   if (TAG_W < 1) begin : g_bad_tag
      $error("mei_cache_ctrl: address too narrow for the geometry");
   end
   if ((1 << OFF_W) != LINE_BYTES || (1 << IDX_W) != SETS) begin : g_bad_pow2
      $error("mei_cache_ctrl: LINE_BYTES and SETS must be powers of two");
   end
   if (LINE_W % WORD_W != 0) begin : g_bad_word
      $error("mei_cache_ctrl: line must hold a whole number of words");
   end

   ctrl_state_e       st_q;
   cache_op_e         op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] wdata_q;
   logic [WAY_W-1:0]  way_q;
   logic              rhit_q;
   logic [WORD_W-1:0] rdata_q;

   logic [TAG_W-1:0]  tag_a   [SETS][WAYS];
   line_state_e       state_a [SETS][WAYS];
   logic [LINE_W-1:0] data_a  [SETS][WAYS];

   logic [IDX_W-1:0]  idx;
   logic [TAG_W-1:0]  ltag;
   logic [WSEL_W-1:0] wsel;
   logic [TAG_W-1:0]  set_tag [WAYS];
   logic [WAYS-1:0]   set_valid;
   logic [WAYS-1:0]   hit_vec;
   logic              hit;
   logic [WAY_W-1:0]  hit_way;
   logic [WAY_W-1:0]  victim;
   line_state_e       hit_st;
   logic              is_ld, is_st;

   logic              dwr_en;
   logic [WAY_W-1:0]  dwr_way;
   logic [LINE_W-1:0] dwr_line;
   logic              upd_touch, upd_fill;
   logic [WAY_W-1:0]  upd_way;

   function automatic logic [WORD_W-1:0] get_word(input logic [LINE_W-1:0] ln,
                                                  input logic [WSEL_W-1:0] s);
      return ln[int'(s)*WORD_W +: WORD_W];
   endfunction

   function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] ln,
                                                  input logic [WSEL_W-1:0] s,
                                                  input logic [WORD_W-1:0] w);
      logic [LINE_W-1:0] r;
      r = ln;
      r[int'(s)*WORD_W +: WORD_W] = w;
      return r;
   endfunction

   // Address split (R2)
   assign idx   = addr_q[OFF_W +: IDX_W];
   assign ltag  = addr_q[ADDR_W-1 -: TAG_W];
   assign wsel  = addr_q[BOFF_W +: WSEL_W];
   assign is_ld = (op_q == OP_LOAD);
   assign is_st = (op_q == OP_STORE);

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         set_tag[w]   = tag_a[idx][w];
         set_valid[w] = (state_a[idx][w] != LS_INV);
      end
   end

   mei_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
      .way_tag   (set_tag),
      .way_valid (set_valid),
      .look_tag  (ltag),
      .hit_vec   (hit_vec),
      .hit       (hit),
      .hit_way   (hit_way)
   );

   assign hit_st    = state_a[idx][hit_way];
   assign upd_fill  = (st_q == S_FILL) && mem_ack;
   assign upd_touch = upd_fill || ((st_q == S_LOOK) && hit && (is_ld || is_st));
   assign upd_way   = (st_q == S_LOOK) ? hit_way : way_q;

   mei_repl #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_repl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_rr    (cfg_rr),
      .set_idx   (idx),
      .way_valid (set_valid),
      .victim    (victim),
      .upd_touch (upd_touch),
      .upd_fill  (upd_fill),
      .upd_way   (upd_way)
   );

   assign req_ready  = (st_q == S_IDLE);
   assign resp_valid = (st_q == S_DONE);
   assign resp_hit   = rhit_q;
   assign resp_rdata = rdata_q;
   assign mem_req    = (st_q == S_EVICT) || (st_q == S_FILL) || (st_q == S_MWB);
   assign mem_we     = (st_q == S_EVICT) || (st_q == S_MWB);
   assign mem_addr   = (st_q == S_FILL) ? {ltag, idx, {OFF_W{1'b0}}}
                                        : {tag_a[idx][way_q], idx, {OFF_W{1'b0}}};
   assign mem_wdata  = data_a[idx][way_q];

   always_comb begin
      dwr_en   = 1'b0;
      dwr_way  = way_q;
      dwr_line = mem_rdata;
      if ((st_q == S_LOOK) && hit && is_st) begin
         dwr_en   = 1'b1;
         dwr_way  = hit_way;
         dwr_line = put_word(data_a[idx][hit_way], wsel, wdata_q);
      end else if (upd_fill) begin
         dwr_en   = 1'b1;
         dwr_line = is_st ? put_word(mem_rdata, wsel, wdata_q) : mem_rdata;
      end
   end

   always_ff @(posedge clk) begin
      if (dwr_en) data_a[idx][dwr_way] <= dwr_line;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         op_q    <= OP_LOAD;
         addr_q  <= '0;
         wdata_q <= '0;
         way_q   <= '0;
         rhit_q  <= 1'b0;
         rdata_q <= '0;
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               tag_a[s][w]   <= '0;
               state_a[s][w] <= LS_INV;
            end
         end
      end else begin
         unique case (st_q)
            S_IDLE: if (req_valid) begin
               op_q    <= cache_op_e'(req_op);
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
               st_q    <= S_LOOK;
            end
            S_LOOK: begin
               rdata_q <= '0;
               rhit_q  <= hit;
               st_q    <= S_DONE;
               case (op_q)
                  OP_LOAD, OP_STORE: begin
                     if (hit) begin
                        if (is_ld) rdata_q <= get_word(data_a[idx][hit_way], wsel);
                        else       state_a[idx][hit_way] <= LS_MOD;
                     end else begin
                        way_q <= victim;
                        st_q  <= (state_a[idx][victim] == LS_MOD) ? S_EVICT : S_FILL;
                     end
                  end
                  OP_CLEAN: if (hit && hit_st == LS_MOD) begin
                     way_q <= hit_way;
                     st_q  <= S_MWB;
                  end
                  OP_INVAL: if (hit) state_a[idx][hit_way] <= LS_INV;
                  OP_FLUSH: begin
                     if (hit && hit_st == LS_MOD) begin
                        way_q <= hit_way;
                        st_q  <= S_MWB;
                     end else if (hit) begin
                        state_a[idx][hit_way] <= LS_INV;
                     end
                  end
                  default: ;
               endcase
            end
            S_EVICT: if (mem_ack) st_q <= S_FILL;
            S_FILL: if (mem_ack) begin
               tag_a[idx][way_q]   <= ltag;
               state_a[idx][way_q] <= is_st ? LS_MOD : LS_EXC;
               if (is_ld) rdata_q <= get_word(mem_rdata, wsel);
               st_q <= S_DONE;
            end
            S_MWB: if (mem_ack) begin
               state_a[idx][way_q] <= (op_q == OP_FLUSH) ? LS_INV : LS_EXC;
               st_q <= S_DONE;
            end
            S_DONE: st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   p_mem_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[OFF_W-1:0] == '0));

   p_hit_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   p_wb_then_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == S_EVICT) && mem_ack) |=> (mem_req && !mem_we));

   p_mem_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

   p_resp_pulse_r14: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> (!resp_valid && req_ready));

   p_idle_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req);

endmodule

// File: tb/mei_cache_ctrl_bench.sv
module mei_cache_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NSET = 256;
   localparam int NWAY = 3;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cfg_rr;
   logic         req_valid;
   logic         req_ready;
   logic [2:0]   req_op;
   logic [31:0]  req_addr;
   logic [31:0]  req_wdata;
   logic         resp_valid;
   logic         resp_hit;
   logic [31:0]  resp_rdata;
   logic         mem_req;
   logic         mem_we;
   logic [31:0]  mem_addr;
   logic [511:0] mem_wdata;
   logic         mem_ack;
   logic [511:0] mem_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   int wb_cnt, fill_cnt;
   logic [31:0]  wb_addr;
   logic [511:0] wb_data;

   logic [511:0] mem_m [logic [25:0]];

   logic [17:0]  m_tag [NSET][NWAY];
   int           m_st  [NSET][NWAY];   // 0 Invalid, 1 Exclusive, 2 Modified
   logic [511:0] m_dat [NSET][NWAY];
   int           m_age [NSET][NWAY];
   int           m_rr  [NSET];

   always #(CLK_PERIOD/2) clk = ~clk;

   mei_cache_ctrl u_mei_cache_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_rr(cfg_rr),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   function automatic logic [511:0] mem_get(input logic [25:0] la);
      logic [511:0] r;
      if (mem_m.exists(la)) return mem_m[la];
      for (int k = 0; k < 16; k++)
         r[k*32 +: 32] = ({6'b0, la} * 32'h9E37_79B1) ^ (k * 32'h0101_0101);
      return r;
   endfunction

   task automatic chk(input bit ok, input string what,
                      input logic [511:0] act, input logic [511:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   task automatic m_touch(input int s, input int w);
      int a;
      a = m_age[s][w];
      for (int k = 0; k < NWAY; k++) begin
         if (k == w) m_age[s][k] = 0;
         else if (m_age[s][k] < a) m_age[s][k]++;
      end
   endtask

   // Reference model: field split as in R2, ops as in R14/R10/R11/R12
   task automatic model(input int op, input logic [31:0] a, input logic [31:0] wd,
                        output bit e_hit, output logic [31:0] e_rd, output int e_wb,
                        output logic [31:0] e_wba, output logic [511:0] e_wbd,
                        output int e_fill);
      int s, ws, hw, v;
      logic [17:0] tg;
      logic [511:0] ln;
      s = int'(a[13:6]); tg = a[31:14]; ws = int'(a[5:2]);
      hw = -1;
      for (int w = 0; w < NWAY; w++)
         if (m_st[s][w] != 0 && m_tag[s][w] == tg) hw = w;
      e_hit = (hw >= 0); e_rd = '0; e_wb = 0; e_wba = '0; e_wbd = '0; e_fill = 0;
      if (op == 0 || op == 1) begin
         if (hw >= 0) begin
            if (op == 0) e_rd = m_dat[s][hw][ws*32 +: 32];
            else begin m_dat[s][hw][ws*32 +: 32] = wd; m_st[s][hw] = 2; end
            m_touch(s, hw);
         end else begin
            v = -1;
            for (int w = NWAY-1; w >= 0; w--) if (m_st[s][w] == 0) v = w;
            if (v < 0) begin
               if (cfg_rr) v = m_rr[s];
               else for (int w = 0; w < NWAY; w++) if (m_age[s][w] == NWAY-1) v = w;
            end
            if (m_st[s][v] == 2) begin
               e_wb = 1; e_wba = {m_tag[s][v], a[13:6], 6'b0}; e_wbd = m_dat[s][v];
            end
            ln = mem_get({tg, a[13:6]});
            if (op == 1) begin ln[ws*32 +: 32] = wd; m_st[s][v] = 2; end
            else begin e_rd = ln[ws*32 +: 32]; m_st[s][v] = 1; end
            m_dat[s][v] = ln; m_tag[s][v] = tg; e_fill = 1;
            m_touch(s, v);
            m_rr[s] = (v + 1) % NWAY;
         end
      end else if (hw >= 0) begin
         if ((op == 2 || op == 4) && m_st[s][hw] == 2) begin
            e_wb = 1; e_wba = {tg, a[13:6], 6'b0}; e_wbd = m_dat[s][hw];
            m_st[s][hw] = (op == 4) ? 0 : 1;
         end else if (op == 3 || op == 4) begin
            m_st[s][hw] = 0;
         end
      end
   endtask

   task automatic do_op(input int op, input logic [31:0] a, input logic [31:0] wd,
                        input string lbl);
      bit e_hit; logic [31:0] e_rd, e_wba; logic [511:0] e_wbd; int e_wb, e_fill;
      int guard;
      model(op, a, wd, e_hit, e_rd, e_wb, e_wba, e_wbd, e_fill);
      wb_cnt = 0; fill_cnt = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'(op); req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      guard = 0;
      while (!resp_valid && guard < 300) begin @(negedge clk); guard++; end
      chk(guard < 300, {lbl, " R14 response pulse"}, 512'(guard), 512'(0));
      chk(resp_hit == e_hit, {lbl, " R3/R6 hit flag"}, 512'(resp_hit), 512'(e_hit));
      chk(resp_rdata == e_rd, {lbl, " R4/R5 read word"}, 512'(resp_rdata), 512'(e_rd));
      chk(wb_cnt == e_wb, {lbl, " R9/R10/R12 write-back count"}, 512'(wb_cnt), 512'(e_wb));
      if (e_wb == 1 && wb_cnt == 1) begin
         chk(wb_addr == e_wba, {lbl, " R9/R13 write-back address"}, 512'(wb_addr), 512'(e_wba));
         chk(wb_data == e_wbd, {lbl, " R9 write-back line"}, wb_data, e_wbd);
      end
      chk(fill_cnt == e_fill, {lbl, " R4/R11 fill count"}, 512'(fill_cnt), 512'(e_fill));
      @(negedge clk);
      chk(req_ready == 1'b1, {lbl, " R14 ready after response"}, 512'(req_ready), 512'(1));
   endtask

   // Memory responder with random acknowledge delay
   initial begin
      mem_ack = 1'b0; mem_rdata = '0;
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         if (mem_req && ($urandom % 3 != 0)) begin
            mem_ack = 1'b1;
            if (mem_we) begin
               wb_cnt++; wb_addr = mem_addr; wb_data = mem_wdata;
               mem_m[mem_addr[31:6]] = mem_wdata;
            end else begin
               fill_cnt++;
               mem_rdata = mem_get(mem_addr[31:6]);
            end
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog R14 actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int s = 0; s < NSET; s++) begin
         m_rr[s] = 0;
         for (int w = 0; w < NWAY; w++) begin
            m_st[s][w] = 0; m_age[s][w] = w; m_tag[s][w] = '0; m_dat[s][w] = '0;
         end
      end
      rst_n = 1'b0; cfg_rr = 1'b0; req_valid = 1'b0; req_op = '0;
      req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", 512'(req_ready), 512'(1));
      chk(resp_valid == 1'b0, "R1 no response after reset", 512'(resp_valid), 512'(0));
      chk(mem_req == 1'b0, "R1 no memory request after reset", 512'(mem_req), 512'(0));

      do_op(0, 32'h0000_150C, 32'h0, "R1 first load misses");
      do_op(1, 32'h0000_1508, 32'hCAFE_0001, "R5 store hit");
      do_op(0, 32'h0000_1508, 32'h0, "R5 reload stored word");
      do_op(2, 32'h0000_153C, 32'h0, "R10/R13 clean dirty line by unaligned address");
      do_op(2, 32'h0000_1500, 32'h0, "R10 clean of clean line");
      do_op(1, 32'h0000_1510, 32'hBEEF_0002, "R5 dirty again");
      do_op(4, 32'h0000_1520, 32'h0, "R12 flush dirty line");
      do_op(0, 32'h0000_1510, 32'h0, "R12 reload after flush");
      do_op(4, 32'h0000_1504, 32'h0, "R12 flush clean line");
      do_op(3, 32'h9999_9940, 32'h0, "R13 invalidate absent line");
      do_op(1, 32'h0004_0000, 32'h1111_1111, "R6 set 0 way fill");
      do_op(1, 32'h0008_0004, 32'h2222_2222, "R6 set 0 way fill");
      do_op(0, 32'h000C_0008, 32'h0, "R6 set 0 way fill");
      do_op(0, 32'h0004_0000, 32'h0, "R7 touch oldest");
      do_op(1, 32'h0010_000C, 32'h4444_4444, "R7/R9 LRU eviction of dirty way");
      do_op(3, 32'h0004_0000, 32'h0, "R11 invalidate dirty line");
      do_op(0, 32'h0004_0000, 32'h0, "R11 dirty data dropped");

      for (int i = 0; i < 3000; i++) begin
         int r, op, sel;
         logic [7:0] set;
         logic [31:0] a;
         if (i == 1500) cfg_rr = 1'b1;   // R8 round-robin half
         r = int'($urandom % 100);
         op = (r < 40) ? 0 : (r < 76) ? 1 : (r < 84) ? 2 : (r < 92) ? 3 : 4;
         sel = int'($urandom % 4);
         set = (sel == 0) ? 8'd0 : (sel == 1) ? 8'd1 : (sel == 2) ? 8'h55 : 8'hFF;
         a = {18'($urandom % 5), set, 4'($urandom), 2'($urandom)};
         do_op(op, a, $urandom, cfg_rr ? "R8 random" : "R7 random");
      end

      summary();
      $finish;
   end

endmodule